// File: doc/BRIEF.md
# Multi-Condition Sample Trigger

This block watches a stream of sampled channel words and raises a single trigger pulse when a programmed combination of conditions is met. Up to four condition slots are available. Each slot can look for a rising or falling transition on one chosen channel, for a masked value match on the whole word, or for the moment the word first enters a masked value. The slot results are merged by an all-of, any-of or odd-parity function. The merged hit can then be held back by a programmable number of further samples before the pulse is issued.

The sample input is a valid-only stream. `smp_valid` marks a word and the block takes every marked word, so it never applies back-pressure and has no ready output. The configuration inputs are plain levels that the user holds steady while the unit is armed. A one-cycle `arm` pulse starts a capture. After the trigger fires, the unit stays silent until it is armed again.

Top module: `trig_unit`

## Requirements
- R1: Each word with `smp_valid` high is registered as the latest sample, and the previous latest becomes the earlier sample. Conditions are judged once per accepted word, and only after at least two words have been accepted since the last `arm`. A word offered in the same cycle as `arm` is dropped.
- R2: Kind code 2'b00 hits when the selected channel was 0 in the earlier sample and is 1 in the latest sample.
- R3: Kind code 2'b01 hits when the selected channel was 1 in the earlier sample and is 0 in the latest sample.
- R4: Kind code 2'b10 hits when the latest sample equals the slot value on every bit whose mask bit is 1. Bits whose mask bit is 0 are ignored.
- R5: Kind code 2'b11 hits when the latest sample matches the masked value and the earlier sample did not match it.
- R6: A slot takes part only if its index is below `cond_count` and its enable bit is set. A slot that does not take part counts as true for all-of and as false for any-of and odd-parity. When no slot takes part, there is no hit.
- R7: `combine_mode` 2'b00 requires every taking-part slot to hit. 2'b01 requires at least one. 2'b10 requires an odd number. 2'b11 behaves as 2'b01.
- R8: With `trig_delay` 0, a hit makes `trig_out` high in the clock cycle after the evaluation cycle. That is two rising edges after the edge that accepted the word.
- R9: With `trig_delay` D>0, a hit starts a wait, and the pulse follows the D-th later accepted word with the same latency as R8. Hits during the wait are ignored.
- R10: `trig_out` is high for exactly one cycle. After it fires, the unit gives no pulse until `arm` is asserted again. An `arm` during a wait cancels the wait.
- R11: During and just after reset, `trig_out` is 0 and the unit is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample word present (always accepted) |
| smp_word | input | CH_W | Sampled channel word |
| arm | input | 1 | One-cycle request to start a capture |
| cond_en | input | NCOND | Per-slot enable |
| cond_kind | input | 2*NCOND | Per-slot kind code, slot i at [2i+1:2i] |
| cond_chan | input | IDX_W*NCOND | Per-slot channel index for edge kinds |
| cond_value | input | CH_W*NCOND | Per-slot match value |
| cond_mask | input | CH_W*NCOND | Per-slot care mask (1 = compared) |
| cond_count | input | CNT_W | Number of leading slots that take part |
| combine_mode | input | 2 | Merge function code |
| trig_delay | input | DLY_W | Samples to hold back the trigger |
| trig_out | output | 1 | One-cycle trigger pulse |

## Verification
The embedded assertions check on every cycle that the pulse lasts one cycle and that a disarmed unit never pulses. They also check that a zero-delay hit fires on the next edge while a non-zero delay does not, that a wait always holds a non-zero count, and that no hit appears when no slot takes part. Other behaviour shows only in the bench's scenarios: the exact cycle of a delayed pulse, edge detection across gaps in the sample stream, and the way each merge mode treats partly hitting slot sets. The bench's reference model follows these cycle by cycle.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    K_RISE  = 2'b00,
    K_FALL  = 2'b01,
    K_MATCH = 2'b10,
    K_ENTER = 2'b11
  } cond_kind_e;

  typedef enum logic [1:0] {
    C_ALL = 2'b00,
    C_ANY = 2'b01,
    C_ODD = 2'b10,
    C_RSV = 2'b11
  } combine_e;
endpackage

// File: rtl/trig_cond.sv
module trig_cond
  import trig_pkg::*;
#(
  parameter int CH_W  = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH_W-1:0]  cur_i,
  input  logic [CH_W-1:0]  prev_i,
  input  logic [1:0]       kind_i,
  input  logic [IDX_W-1:0] chan_i,
  input  logic [CH_W-1:0]  value_i,
  input  logic [CH_W-1:0]  mask_i,
  output logic             hit_o
);
  logic match_now, match_old, bit_now, bit_old;
  cond_kind_e kind;

  assign kind      = cond_kind_e'(kind_i);
  assign match_now = ((cur_i  ^ value_i) & mask_i) == '0;
  assign match_old = ((prev_i ^ value_i) & mask_i) == '0;
  assign bit_now   = cur_i[chan_i];
  assign bit_old   = prev_i[chan_i];

  always_comb begin
    unique case (kind)
      K_RISE:  hit_o = !bit_old && bit_now;
      K_FALL:  hit_o = bit_old && !bit_now;
      K_MATCH: hit_o = match_now;
      K_ENTER: hit_o = match_now && !match_old;
      default: hit_o = 1'b0;
    endcase
  end

  // R4: a match hit means the cared bits of the sample equal those of the value
  a_r4_match_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_MATCH && hit_o) |-> ((cur_i & mask_i) == (value_i & mask_i)));
  // R5: an entry hit never occurs while the earlier sample already matched
  a_r5_enter_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_ENTER && hit_o) |-> ((prev_i & mask_i) != (value_i & mask_i)));
endmodule

// File: rtl/trig_combine.sv
module trig_combine
  import trig_pkg::*;
#(
  parameter int NCOND = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCOND-1:0] hits_i,
  input  logic [NCOND-1:0] en_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       mode_i,
  output logic             hit_o
);
  logic [NCOND-1:0] active;
  logic all_v, any_v, odd_v;

  for (genvar i = 0; i < NCOND; i++) begin : g_act
    assign active[i] = en_i[i] && (i < int'(count_i));
  end

  always_comb begin
    all_v = 1'b1;
    any_v = 1'b0;
    odd_v = 1'b0;
    for (int i = 0; i < NCOND; i++) begin
      if (active[i]) begin
        all_v = all_v & hits_i[i];
        any_v = any_v | hits_i[i];
        odd_v = odd_v ^ hits_i[i];
      end
    end
  end

  always_comb begin
    if (active == '0) hit_o = 1'b0;
    else begin
      unique case (combine_e'(mode_i))
        C_ALL:   hit_o = all_v;
        C_ODD:   hit_o = odd_v;
        default: hit_o = any_v;
      endcase
    end
  end

  // R6: with no slot taking part the merged hit stays low
  a_r6_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (count_i == '0 || en_i == '0) |-> !hit_o);
endmodule

// File: rtl/trig_seq.sv
module trig_seq #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             new_i,
  input  logic             ready_i,
  input  logic             hit_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             trig_o
);
  logic             armed_q, wait_q, trig_q;
  logic [DLY_W-1:0] cnt_q;
  logic             fire;
  logic             start;

  assign start = armed_q && !wait_q && new_i && ready_i && hit_i;
  assign fire  = armed_q && new_i &&
                 ((wait_q && cnt_q == DLY_W'(1)) || (start && dly_i == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      wait_q  <= 1'b0;
      cnt_q   <= '0;
      trig_q  <= 1'b0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      wait_q  <= 1'b0;
      cnt_q   <= '0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= fire;
      if (fire) begin
        armed_q <= 1'b0;
        wait_q  <= 1'b0;
        cnt_q   <= '0;
      end else if (armed_q && new_i && wait_q) begin
        cnt_q <= cnt_q - DLY_W'(1);
      end else if (start) begin
        wait_q <= 1'b1;
        cnt_q  <= dly_i;
      end
    end
  end

  assign trig_o = trig_q;

  // R10: the pulse never lasts more than one cycle
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> !trig_q);
  // R10: a disarmed unit without a new arm stays silent
  a_r10_quiet_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !arm_i) |=> !trig_q);
  // R8: an immediate hit fires on the next edge
  a_r8_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dly_i == '0 && !arm_i) |=> trig_q);
  // R9: a delayed hit does not fire at once
  a_r9_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dly_i != '0 && !arm_i) |=> !trig_q);
  // R9: while waiting the counter is never exhausted
  a_r9_wait_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q |-> (cnt_q != '0));
endmodule

// File: rtl/trig_unit.sv
module trig_unit #(
  parameter int CH_W  = 16,
  parameter int NCOND = 4,
  parameter int DLY_W = 8,
  parameter int IDX_W = $clog2(CH_W),
  parameter int CNT_W = $clog2(NCOND + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_valid,
  input  logic [CH_W-1:0]        smp_word,
  input  logic                   arm,
  input  logic [NCOND-1:0]       cond_en,
  input  logic [2*NCOND-1:0]     cond_kind,
  input  logic [IDX_W*NCOND-1:0] cond_chan,
  input  logic [CH_W*NCOND-1:0]  cond_value,
  input  logic [CH_W*NCOND-1:0]  cond_mask,
  input  logic [CNT_W-1:0]       cond_count,
  input  logic [1:0]             combine_mode,
  input  logic [DLY_W-1:0]       trig_delay,
  output logic                   trig_out
);
  localparam logic [1:0] HIST_FULL = 2'd2;

  logic [CH_W-1:0]  cur_q, prev_q;
  logic [1:0]       hist_q;
  logic             new_q;
  logic [NCOND-1:0] slot_hit;
  logic             merged_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
      hist_q <= '0;
      new_q  <= 1'b0;
    end else if (arm) begin
      hist_q <= '0;
      new_q  <= 1'b0;
    end else begin
      new_q <= smp_valid;
      if (smp_valid) begin
        prev_q <= cur_q;
        cur_q  <= smp_word;
        if (hist_q != HIST_FULL) hist_q <= hist_q + 2'd1;
      end
    end
  end

  for (genvar i = 0; i < NCOND; i++) begin : g_slot
    trig_cond #(.CH_W(CH_W), .IDX_W(IDX_W)) u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .cur_i   (cur_q),
      .prev_i  (prev_q),
      .kind_i  (cond_kind[2*i +: 2]),
      .chan_i  (cond_chan[IDX_W*i +: IDX_W]),
      .value_i (cond_value[CH_W*i +: CH_W]),
      .mask_i  (cond_mask[CH_W*i +: CH_W]),
      .hit_o   (slot_hit[i])
    );
  end

  trig_combine #(.NCOND(NCOND), .CNT_W(CNT_W)) u_comb (
    .clk     (clk),
    .rst_n   (rst_n),
    .hits_i  (slot_hit),
    .en_i    (cond_en),
    .count_i (cond_count),
    .mode_i  (combine_mode),
    .hit_o   (merged_hit)
  );

  trig_seq #(.DLY_W(DLY_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (arm),
    .new_i   (new_q),
    .ready_i (hist_q == HIST_FULL),
    .hit_i   (merged_hit),
    .dly_i   (trig_delay),
    .trig_o  (trig_out)
  );

  // R1: a fresh-sample flag only follows an accepted word with no arm
  a_r1_new_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    new_q |-> $past(smp_valid && !arm));
  // R1: the history count never passes two
  a_r1_hist_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hist_q <= HIST_FULL);
endmodule

// File: tb/trig_unit_bench.sv
module trig_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CH_W = 16, NCOND = 4, DLY_W = 8, IDX_W = 4, CNT_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0, arm = 1'b0;
  logic [CH_W-1:0] smp_word = '0;
  logic [NCOND-1:0] cond_en = '0;
  logic [2*NCOND-1:0] cond_kind = '0;
  logic [IDX_W*NCOND-1:0] cond_chan = '0;
  logic [CH_W*NCOND-1:0] cond_value = '0, cond_mask = '0;
  logic [CNT_W-1:0] cond_count = '0;
  logic [1:0] combine_mode = '0;
  logic [DLY_W-1:0] trig_delay = '0;
  logic trig_out;

  trig_unit u_trig_unit (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_word(smp_word),
    .arm(arm), .cond_en(cond_en), .cond_kind(cond_kind), .cond_chan(cond_chan),
    .cond_value(cond_value), .cond_mask(cond_mask), .cond_count(cond_count),
    .combine_mode(combine_mode), .trig_delay(trig_delay), .trig_out(trig_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, pulses = 0;
  string tag = "R11";

  // reference model state
  int m_cur = 0, m_prev = 0, m_hist = 0, m_cnt = 0;
  bit m_new = 0, m_armed = 0, m_wait = 0, m_trig = 0;

  function automatic bit slot_hit(int i);
    int kind = int'(cond_kind[2*i +: 2]);
    int ch   = int'(cond_chan[IDX_W*i +: IDX_W]);
    int val  = int'(cond_value[CH_W*i +: CH_W]);
    int msk  = int'(cond_mask[CH_W*i +: CH_W]);
    bit now_b = ((m_cur >> ch) & 1) != 0;
    bit old_b = ((m_prev >> ch) & 1) != 0;
    bit mn = ((m_cur & msk) == (val & msk));
    bit mo = ((m_prev & msk) == (val & msk));
    case (kind)
      0: return !old_b && now_b;
      1: return old_b && !now_b;
      2: return mn;
      default: return mn && !mo;
    endcase
  endfunction

  function automatic bit model_hit();
    int n_part = 0, n_hit = 0;
    for (int i = 0; i < NCOND; i++)
      if (cond_en[i] && i < int'(cond_count)) begin
        n_part++;
        if (slot_hit(i)) n_hit++;
      end
    if (n_part == 0) return 0;
    case (combine_mode)
      2'b00: return n_hit == n_part;
      2'b10: return (n_hit % 2) == 1;
      default: return n_hit > 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = 0; m_prev = 0; m_hist = 0; m_cnt = 0;
      m_new = 0; m_armed = 0; m_wait = 0; m_trig = 0;
    end else begin
      bit h, fire;
      h = model_hit();
      fire = 0;
      if (arm) begin
        m_armed = 1; m_wait = 0; m_cnt = 0; m_hist = 0; m_new = 0; m_trig = 0;
      end else begin
        if (m_armed && m_new) begin
          if (m_wait) begin
            if (m_cnt == 1) fire = 1; else m_cnt--;
          end else if (m_hist == 2 && h) begin
            if (trig_delay == 0) fire = 1;
            else begin m_wait = 1; m_cnt = int'(trig_delay); end
          end
        end
        if (fire) begin m_armed = 0; m_wait = 0; m_cnt = 0; end
        m_trig = fire;
        m_new = smp_valid;
        if (smp_valid) begin
          m_prev = m_cur; m_cur = int'(smp_word);
          if (m_hist < 2) m_hist++;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(trig_out == m_trig, tag, int'(trig_out), int'(m_trig));
      if (trig_out) pulses++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sample(int w);
    smp_valid = 1'b1; smp_word = CH_W'(w);
    tick(1);
    smp_valid = 1'b0;
  endtask

  task automatic do_arm();
    arm = 1'b1; tick(1); arm = 1'b0;
  endtask

  task automatic set_slot(int i, int kind, int ch, int val, int msk);
    cond_kind[2*i +: 2]          = 2'(kind);
    cond_chan[IDX_W*i +: IDX_W]  = IDX_W'(ch);
    cond_value[CH_W*i +: CH_W]   = CH_W'(val);
    cond_mask[CH_W*i +: CH_W]    = CH_W'(msk);
  endtask

  task automatic expect_pulses(string req, int exp);
    tick(3);
    chk(pulses == exp, req, pulses, exp);
    pulses = 0;
  endtask

  initial begin
    tick(2);
    chk(trig_out == 1'b0, "R11", int'(trig_out), 0);
    rst_n = 1'b1;
    tick(2);
    chk(trig_out == 1'b0, "R11", int'(trig_out), 0);

    // R2 rising edge on channel 3
    tag = "R2"; cond_en = 4'b0001; cond_count = 3'd1; combine_mode = 2'b01;
    set_slot(0, 0, 3, 0, 0);
    do_arm(); sample(0); sample(0); sample(8);
    expect_pulses("R2", 1);

    // R3 falling edge on channel 5
    tag = "R3"; set_slot(0, 1, 5, 0, 0);
    do_arm(); sample('h20); sample('h20); sample(0);
    expect_pulses("R3", 1);

    // R4 masked match; high byte ignored
    tag = "R4"; set_slot(0, 2, 0, 'h00A5, 'h00FF);
    do_arm(); sample('h00A4); sample('h00A4);
    expect_pulses("R4", 0);
    sample('h1200); sample('h12A5);
    expect_pulses("R4", 1);

    // R5 entry into a value
    tag = "R5"; set_slot(0, 3, 0, 'h00A5, 'h00FF);
    do_arm(); sample('hA5); sample('hA5); sample('hA5);
    expect_pulses("R5", 0);
    sample(0); sample('hA5);
    expect_pulses("R5", 1);

    // R7 merge modes with two slots
    tag = "R7"; cond_en = 4'b0011; cond_count = 3'd2;
    set_slot(0, 0, 0, 0, 0); set_slot(1, 2, 0, 'h10, 'h10);
    combine_mode = 2'b00;
    do_arm(); sample(0); sample(1); sample('h10); sample('h11);
    expect_pulses("R7", 1);
    combine_mode = 2'b10;
    do_arm(); sample('h10); sample('h11); sample(0); sample(1);
    expect_pulses("R7", 1);
    combine_mode = 2'b01;
    do_arm(); sample(0); sample('h10);
    expect_pulses("R7", 1);
    combine_mode = 2'b11;
    do_arm(); sample(0); sample('h10);
    expect_pulses("R7", 1);

    // R6 slot participation
    tag = "R6"; combine_mode = 2'b00;
    set_slot(0, 2, 0, 'h10, 'h10); set_slot(1, 2, 0, 'hFFFF, 'hFFFF);
    cond_en = 4'b0011; cond_count = 3'd1;
    do_arm(); sample(0); sample('h10);
    expect_pulses("R6", 1);
    cond_en = 4'b0001; cond_count = 3'd2;
    do_arm(); sample(0); sample('h10);
    expect_pulses("R6", 1);
    cond_en = 4'b0011; cond_count = 3'd0;
    do_arm(); sample('h10); sample('h10);
    expect_pulses("R6", 0);
    cond_en = 4'b0000; cond_count = 3'd4;
    do_arm(); sample('h10); sample('h10);
    expect_pulses("R6", 0);

    // R9 delayed trigger with hits during the wait
    tag = "R9"; cond_en = 4'b0001; cond_count = 3'd1; combine_mode = 2'b01;
    trig_delay = 8'd3;
    do_arm(); sample('h10); sample('h10); sample('h10); tick(2);
    sample(0); tick(1);
    chk(pulses == 0, "R9", pulses, 0);
    sample('h10);
    expect_pulses("R9", 1);

    // R10 quiet after firing, re-arm, arm cancels wait
    tag = "R10"; sample('h10); sample('h10);
    expect_pulses("R10", 0);
    trig_delay = 8'd5;
    do_arm(); sample('h10); sample('h10); do_arm();
    sample(0); sample(0); sample(0); sample(0); sample(0); sample(0);
    expect_pulses("R10", 0);
    trig_delay = 8'd0;
    do_arm(); sample('h10); sample('h10);
    expect_pulses("R8", 1);

    // R1 history and gaps
    tag = "R1"; set_slot(0, 0, 3, 0, 0);
    sample(0); do_arm(); sample(8); sample(8);
    expect_pulses("R1", 0);
    do_arm(); sample(0); tick(2); sample(8);
    expect_pulses("R1", 1);
    smp_valid = 1'b1; smp_word = 16'h0000; arm = 1'b1; tick(1);
    arm = 1'b0; smp_word = 16'h0008; tick(1); smp_valid = 1'b0;
    sample(8);
    expect_pulses("R1", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule